// File: doc/BRIEF.md
# Burst-of-two double-data-rate synchronous SRAM

This block is a synthesizable model of a synchronous static RAM that has one address bus and moves two data words per transaction. A command is sampled on each rising clock edge: an active-low load strobe starts a transaction, and a read select picks its direction. A write takes its two data words one cycle after the address. A read returns its two words two cycles after the address. The first word of a burst goes to the captured address. The second goes to that address with bit 0 inverted, so the burst wraps inside an aligned pair of words.

The block uses a single clock, so the two data edges of a real double-data-rate part are modelled as two beats that are present in the same cycle. Beat 0 and beat 1 each have their own data bus, their own pair of active-low byte selects and their own output-enable. When no read data is due, the output-enables are low and the data buses read zero. This is how the model represents high impedance. A clock-enable input held low freezes every pipeline stage and the outputs, which stands in for a stopped clock. A new command can be accepted on every enabled cycle, whatever the previous command was.

Top module: `ddr_b2_sram`

## Requirements
- R1: When `cmd_load_n`=0 and `cmd_read`=0 at an enabled edge t, a write starts at address A = `addr`. The data and selects of beat 0 and beat 1 are sampled at the next enabled edge. Beat 0 is stored at A and beat 1 at the burst partner of A.
- R2: When `cmd_load_n`=0 and `cmd_read`=1 at an enabled edge t, both output-enables are 1 and both read buses carry the stored words during the single cycle that follows the second enabled edge after t. Beat 0 carries the word at A and beat 1 the word at the burst partner.
- R3: The burst partner of A is A with bit 0 inverted and every higher bit unchanged. For an odd A the partner is A-1, and the address never carries into bit 1.
- R4: When `cmd_load_n`=1 at an enabled edge, no operation starts. `cmd_read`, `addr` and the write data are ignored, and the memory contents stay unchanged.
- R5: The byte selects of a beat are active low. Bit 0 low writes data bits 8:0, bit 1 low writes data bits 17:9, and a select that is high leaves its byte unchanged. Both high writes nothing for that beat.
- R6: Beat 0 and beat 1 of one burst apply their own selects independently, so the two words of a burst may use different masks.
- R7: In every cycle in which no read data is due, both output-enables are 0 and both read data buses are all zeros.
- R8: Asynchronous reset (`rst_n`=0) clears any pending write and any read in flight. The outputs become idle (output-enables 0, data zero) and stay idle until a new read completes. Memory contents are not cleared.
- R9: While `clk_en`=0, no command is sampled, no write is performed, every pipeline stage holds its state and the outputs keep their previous values. The latencies in R1 and R2 count enabled edges only.
- R10: A read issued in the cycle right after a write to the same address returns the newly written data.
- R11: A command is accepted on every enabled cycle. Back-to-back reads, back-to-back writes and alternating writes and reads all complete with the latencies of R1 and R2 and without stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock enable; 0 freezes the whole block |
| cmd_load_n | input | 1 | Active-low load strobe that starts a transaction |
| cmd_read | input | 1 | 1 selects a read, 0 a write; used only when loading |
| addr | input | AW (8) | Burst base address |
| wr0_data | input | WORD_W (18) | Write data for beat 0 |
| wr0_sel_n | input | 2 | Active-low byte selects for beat 0 |
| wr1_data | input | WORD_W (18) | Write data for beat 1 |
| wr1_sel_n | input | 2 | Active-low byte selects for beat 1 |
| rd0_data | output | WORD_W (18) | Read data for beat 0, zero when idle |
| rd0_oe | output | 1 | Beat 0 output enable (0 = high impedance) |
| rd1_data | output | WORD_W (18) | Read data for beat 1, zero when idle |
| rd1_oe | output | 1 | Beat 1 output enable (0 = high impedance) |

## Verification
A corrupted address or mask register shows up as a wrong word on a read beat. It appears at the latest at the next read that touches the damaged location, and the sweep reads back every location it writes. A lost or doubled pipeline valid shows up within two enabled cycles as an output-enable that is high one cycle early, one cycle late or not at all. Because idle data must read zero, this is seen on both beats in the same cycle. A clock enable that fails to freeze a stage moves a read result to a different cycle, or lets data that should have been ignored into memory. The later readback of that address exposes it.

// File: rtl/ddr_b2_sram_pkg.sv
package ddr_b2_sram_pkg;

   localparam int unsigned BEATS = 2;

   typedef enum logic [1:0] {
      OP_NOP   = 2'd0,
      OP_WRITE = 2'd1,
      OP_READ  = 2'd2
   } op_e;

   function automatic op_e decode_op(input logic load_n, input logic read_sel);
      op_e res;
      if (load_n)        res = OP_NOP;
      else if (read_sel) res = OP_READ;
      else               res = OP_WRITE;
      return res;
   endfunction

endpackage

// File: rtl/ddr_b2_sram_ctrl.sv
module ddr_b2_sram_ctrl
   import ddr_b2_sram_pkg::*;
#(
   parameter int unsigned AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clk_en,
   input  logic          cmd_load_n,
   input  logic          cmd_read,
   input  logic [AW-1:0] addr,
   output logic          wr_vld,
   output logic [AW-1:0] wr_base,
   output logic          rd_vld,
   output logic [AW-1:0] rd_base
);

   op_e op;

   always_comb op = decode_op(cmd_load_n, cmd_read);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_vld  <= 1'b0;
         rd_vld  <= 1'b0;
         wr_base <= '0;
         rd_base <= '0;
      end else if (clk_en) begin
         wr_vld <= (op == OP_WRITE);
         rd_vld <= (op == OP_READ);
         if (op == OP_WRITE) wr_base <= addr;
         if (op == OP_READ)  rd_base <= addr;
      end
   end

   AST_NOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && cmd_load_n) |=> (!wr_vld && !rd_vld)); // R4

   AST_WR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && !cmd_load_n && !cmd_read) |=> (wr_vld && wr_base == $past(addr))); // R1

   AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_vld && rd_vld)); // R11

endmodule

// File: rtl/ddr_b2_sram_array.sv
module ddr_b2_sram_array #(
   parameter int unsigned AW     = 8,
   parameter int unsigned WORD_W = 18,
   parameter int unsigned LANE_W = 9,
   parameter int unsigned BEATS  = 2
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic                                      clk_en,
   input  logic [BEATS-1:0][AW-1:0]                  wr_addr,
   input  logic [BEATS-1:0][(WORD_W/LANE_W)-1:0]     wr_lane_en,
   input  logic [BEATS-1:0][WORD_W-1:0]              wr_data,
   input  logic                                      rd_en,
   input  logic [BEATS-1:0][AW-1:0]                  rd_addr,
   output logic [BEATS-1:0][WORD_W-1:0]              rd_data
);

   localparam int unsigned LANES = WORD_W / LANE_W;
   localparam int unsigned DEPTH = 1 << AW;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0]             mem [DEPTH];
      logic [BEATS-1:0][LANE_W-1:0]  rd_q;

      always_ff @(posedge clk) begin
         if (clk_en) begin
            for (int b = 0; b < BEATS; b++) begin
               if (wr_lane_en[b][l]) mem[wr_addr[b]] <= wr_data[b][l*LANE_W +: LANE_W];
               if (rd_en)            rd_q[b]         <= mem[rd_addr[b]];
            end
         end
      end

      for (genvar b = 0; b < BEATS; b++) begin : g_out
         assign rd_data[b][l*LANE_W +: LANE_W] = rd_q[b];
      end
   end

   AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en |-> !(rd_en && (|wr_lane_en))); // R10

   AST_PORTS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
      ((|wr_lane_en[0]) && (|wr_lane_en[BEATS-1])) |-> (wr_addr[0] != wr_addr[BEATS-1])); // R3

endmodule

// File: rtl/ddr_b2_sram_rdout.sv
module ddr_b2_sram_rdout #(
   parameter int unsigned WORD_W = 18,
   parameter int unsigned BEATS  = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clk_en,
   input  logic                         rd_issue,
   input  logic [BEATS-1:0][WORD_W-1:0] arr_data,
   output logic [BEATS-1:0][WORD_W-1:0] out_data,
   output logic [BEATS-1:0]             out_oe
);

   logic due_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      due_q <= 1'b0;
      else if (clk_en) due_q <= rd_issue;
   end

   for (genvar b = 0; b < BEATS; b++) begin : g_beat
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_oe[b]   <= 1'b0;
            out_data[b] <= '0;
         end else if (clk_en) begin
            out_oe[b]   <= due_q;
            out_data[b] <= due_q ? arr_data[b] : '0;
         end
      end

      AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         !out_oe[b] |-> (out_data[b] == '0)); // R7
   end

   AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |=> ($stable(out_data) && $stable(out_oe))); // R9

endmodule

// File: rtl/ddr_b2_sram.sv
module ddr_b2_sram
   import ddr_b2_sram_pkg::*;
#(
   parameter int unsigned AW     = 8,
   parameter int unsigned WORD_W = 18,
   parameter int unsigned LANE_W = 9
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clk_en,
   input  logic                         cmd_load_n,
   input  logic                         cmd_read,
   input  logic [AW-1:0]                addr,
   input  logic [WORD_W-1:0]            wr0_data,
   input  logic [(WORD_W/LANE_W)-1:0]   wr0_sel_n,
   input  logic [WORD_W-1:0]            wr1_data,
   input  logic [(WORD_W/LANE_W)-1:0]   wr1_sel_n,
   output logic [WORD_W-1:0]            rd0_data,
   output logic                         rd0_oe,
   output logic [WORD_W-1:0]            rd1_data,
   output logic                         rd1_oe
);

   localparam int unsigned LANES = WORD_W / LANE_W;

   if (AW < 1) begin : g_bad_aw
      $error("ddr_b2_sram: AW must be at least 1");
   end
   if (LANE_W == 0 || (WORD_W % LANE_W) != 0) begin : g_bad_lane
      $error("ddr_b2_sram: WORD_W must be a whole multiple of LANE_W");
   end

   logic                          wr_vld;
   logic                          rd_vld;
   logic [AW-1:0]                 wr_base;
   logic [AW-1:0]                 rd_base;
   logic [BEATS-1:0][AW-1:0]      beat_wr_addr;
   logic [BEATS-1:0][AW-1:0]      beat_rd_addr;
   logic [BEATS-1:0][WORD_W-1:0]  beat_wr_data;
   logic [BEATS-1:0][LANES-1:0]   beat_sel_n;
   logic [BEATS-1:0][LANES-1:0]   beat_lane_en;
   logic [BEATS-1:0][WORD_W-1:0]  arr_rd_data;
   logic [BEATS-1:0][WORD_W-1:0]  out_data;
   logic [BEATS-1:0]              out_oe;

   assign beat_wr_data[0] = wr0_data;
   assign beat_wr_data[1] = wr1_data;
   assign beat_sel_n[0]   = wr0_sel_n;
   assign beat_sel_n[1]   = wr1_sel_n;

   for (genvar b = 0; b < BEATS; b++) begin : g_burst
      assign beat_wr_addr[b] = wr_base ^ AW'(b);
      assign beat_rd_addr[b] = rd_base ^ AW'(b);
      assign beat_lane_en[b] = wr_vld ? ~beat_sel_n[b] : '0;
   end

   ddr_b2_sram_ctrl #(
      .AW (AW)
   ) i_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .clk_en     (clk_en),
      .cmd_load_n (cmd_load_n),
      .cmd_read   (cmd_read),
      .addr       (addr),
      .wr_vld     (wr_vld),
      .wr_base    (wr_base),
      .rd_vld     (rd_vld),
      .rd_base    (rd_base)
   );

   ddr_b2_sram_array #(
      .AW     (AW),
      .WORD_W (WORD_W),
      .LANE_W (LANE_W),
      .BEATS  (BEATS)
   ) i_array (
      .clk        (clk),
      .rst_n      (rst_n),
      .clk_en     (clk_en),
      .wr_addr    (beat_wr_addr),
      .wr_lane_en (beat_lane_en),
      .wr_data    (beat_wr_data),
      .rd_en      (rd_vld),
      .rd_addr    (beat_rd_addr),
      .rd_data    (arr_rd_data)
   );

   ddr_b2_sram_rdout #(
      .WORD_W (WORD_W),
      .BEATS  (BEATS)
   ) i_rdout (
      .clk      (clk),
      .rst_n    (rst_n),
      .clk_en   (clk_en),
      .rd_issue (rd_vld),
      .arr_data (arr_rd_data),
      .out_data (out_data),
      .out_oe   (out_oe)
   );

   assign rd0_data = out_data[0];
   assign rd1_data = out_data[1];
   assign rd0_oe   = out_oe[0];
   assign rd1_oe   = out_oe[1];

   AST_BEATS_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
      rd0_oe == rd1_oe); // R2

   AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!rd0_oe && !rd1_oe)); // R8

endmodule

// File: tb/test_ddr_b2_sram.sv
module test_ddr_b2_sram;

   localparam int AW    = 8;
   localparam int W     = 18;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          clk_en;
   logic          cmd_load_n;
   logic          cmd_read;
   logic [AW-1:0] addr;
   logic [W-1:0]  wr0_data, wr1_data;
   logic [1:0]    wr0_sel_n, wr1_sel_n;
   logic [W-1:0]  rd0_data, rd1_data;
   logic          rd0_oe, rd1_oe;

   always #10 clk = ~clk;

   ddr_b2_sram #(.AW(AW), .WORD_W(W), .LANE_W(9)) i_ddr_b2_sram (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cmd_load_n(cmd_load_n),
      .cmd_read(cmd_read), .addr(addr), .wr0_data(wr0_data), .wr0_sel_n(wr0_sel_n),
      .wr1_data(wr1_data), .wr1_sel_n(wr1_sel_n), .rd0_data(rd0_data), .rd0_oe(rd0_oe),
      .rd1_data(rd1_data), .rd1_oe(rd1_oe)
   );

   int errors = 0;
   int checks = 0;
   int seed   = 1;
   string cur_tag = "R1";
   bit last_ce = 1'b1;

   logic [W-1:0]  ref_mem [DEPTH];
   logic          m_wr_pend;
   logic [AW-1:0] m_wr_addr;
   logic          p1_v, p2_v, o_v;
   logic [W-1:0]  p1_d0, p1_d1, p2_d0, p2_d1, o_d0, o_d1;
   string         p1_t, p2_t, o_t;

   function automatic logic [AW-1:0] partner(input logic [AW-1:0] a);
      return {a[AW-1:1], ~a[0]};
   endfunction

   function automatic logic [W-1:0] pat(input int s, input int k);
      return W'((s * 1237 + k * 4099 + 17) ^ (s << 7));
   endfunction

   function automatic logic [W-1:0] merge(input logic [W-1:0] old_w, input logic [W-1:0] new_w,
                                          input logic [1:0] sel_n);
      logic [W-1:0] r;
      r = old_w;
      if (!sel_n[0]) r[8:0]  = new_w[8:0];
      if (!sel_n[1]) r[17:9] = new_w[17:9];
      return r;
   endfunction

   task automatic check_beat(input string tag, input int beat, input logic oe, input logic [W-1:0] d,
                             input logic eoe, input logic [W-1:0] ed);
      checks++;
      if (oe !== eoe || d !== ed) begin
         errors++;
         $display("FAIL %s beat %0d: actual oe=%0b data=%h, expected oe=%0b data=%h",
                  tag, beat, oe, d, eoe, ed);
      end
   endtask

   task automatic clear_model();
      m_wr_pend = 1'b0; m_wr_addr = '0;
      p1_v = 1'b0; p2_v = 1'b0; o_v = 1'b0;
      p1_d0 = '0; p1_d1 = '0; p2_d0 = '0; p2_d1 = '0; o_d0 = '0; o_d1 = '0;
      p1_t = "R7"; p2_t = "R7"; o_t = "R7";
   endtask

   // Called at a falling edge: checks outputs, drives the next command, advances the model.
   task automatic step(input bit ce, input bit ldn, input bit rd, input logic [AW-1:0] a,
                       input logic [1:0] s0, input logic [1:0] s1);
      string t;
      logic  nv;
      logic [W-1:0] n0, n1, d0, d1;
      t = !last_ce ? "R9" : (o_v ? o_t : "R7");
      check_beat(t, 0, rd0_oe, rd0_data, o_v, o_v ? o_d0 : '0);
      check_beat(t, 1, rd1_oe, rd1_data, o_v, o_v ? o_d1 : '0);
      d0 = pat(seed, 3); d1 = pat(seed, 7); seed++;
      clk_en = ce; cmd_load_n = ldn; cmd_read = rd; addr = a;
      wr0_data = d0; wr1_data = d1; wr0_sel_n = s0; wr1_sel_n = s1;
      if (ce) begin
         if (m_wr_pend) begin
            ref_mem[m_wr_addr]          = merge(ref_mem[m_wr_addr], d0, s0);
            ref_mem[partner(m_wr_addr)] = merge(ref_mem[partner(m_wr_addr)], d1, s1);
         end
         nv = !ldn && rd;
         n0 = ref_mem[a];
         n1 = ref_mem[partner(a)];
         o_v = p2_v; o_d0 = p2_d0; o_d1 = p2_d1; o_t = p2_t;
         p2_v = p1_v; p2_d0 = p1_d0; p2_d1 = p1_d1; p2_t = p1_t;
         p1_v = nv; p1_d0 = n0; p1_d1 = n1; p1_t = cur_tag;
         m_wr_pend = !ldn && !rd;
         if (!ldn && !rd) m_wr_addr = a;
      end
      last_ce = ce;
      @(negedge clk);
   endtask

   task automatic nops(input int n);
      for (int i = 0; i < n; i++) step(1, 1, 0, '0, 2'b11, 2'b11);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      clk_en = 1'b1; cmd_load_n = 1'b1; cmd_read = 1'b0;
      repeat (2) @(negedge clk);
      clear_model();
      check_beat("R8", 0, rd0_oe, rd0_data, 1'b0, '0);
      check_beat("R8", 1, rd1_oe, rd1_data, 1'b0, '0);
      rst_n = 1'b1;
      last_ce = 1'b1;
      @(negedge clk);
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
      $finish;
   end

   initial begin
      logic [1:0] pm0, pm1;
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = 'x;
      clear_model();
      clk_en = 1'b1; cmd_load_n = 1'b1; cmd_read = 1'b0; addr = '0;
      wr0_data = '0; wr1_data = '0; wr0_sel_n = 2'b11; wr1_sel_n = 2'b11;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      do_reset(); // R8 reset state

      // R1 R11: back-to-back full writes filling the memory
      cur_tag = "R1";
      for (int a = 0; a < DEPTH; a += 2) step(1, 0, 0, AW'(a), 2'b00, 2'b00);
      step(1, 1, 1, '0, 2'b00, 2'b00);
      // R2: back-to-back reads at even bases
      cur_tag = "R2";
      for (int a = 0; a < DEPTH; a += 2) step(1, 0, 1, AW'(a), 2'b11, 2'b11);
      // R3: odd bases wrap to A-1
      cur_tag = "R3";
      for (int a = 1; a < DEPTH; a += 2) step(1, 0, 1, AW'(a), 2'b11, 2'b11);
      for (int a = 3; a < 40; a += 4) step(1, 0, 0, AW'(a), 2'b00, 2'b00);
      step(1, 1, 0, '0, 2'b00, 2'b00);
      for (int a = 2; a < 40; a += 1) step(1, 0, 1, AW'(a), 2'b11, 2'b11);
      step(1, 0, 1, AW'(DEPTH - 1), 2'b11, 2'b11);
      nops(3);

      // R5 R6: sweep every mask pair over both beats
      cur_tag = "R5";
      pm0 = 2'b11; pm1 = 2'b11;
      for (int m = 0; m < 16; m++) begin
         step(1, 0, 0, AW'(64 + 2 * m), pm0, pm1);
         pm0 = 2'(m); pm1 = 2'(m >> 2);
      end
      step(1, 1, 0, '0, pm0, pm1);
      for (int m = 0; m < 16; m++) begin
         cur_tag = ((m & 3) != (m >> 2)) ? "R6" : "R5";
         step(1, 0, 1, AW'(64 + 2 * m), 2'b11, 2'b11);
      end
      nops(3);

      // R4: NOPs with read select toggling and full-mask junk data
      cur_tag = "R4";
      for (int i = 0; i < 16; i++) step(1, 1, i[0], AW'(i * 7), 2'b00, 2'b00);
      for (int i = 0; i < 16; i++) step(1, 0, 1, AW'(i * 7), 2'b11, 2'b11);
      nops(3);

      // R10: read the cycle right after a write to the same base
      cur_tag = "R10";
      for (int i = 0; i < 8; i++) begin
         step(1, 0, 0, AW'(i * 9 + 3), 2'b11, 2'b11);
         step(1, 0, 1, AW'(i * 9 + 3), 2'b00, (i[0] ? 2'b01 : 2'b00));
      end
      // R11: alternating writes and reads to different bases
      cur_tag = "R11";
      for (int i = 0; i < 12; i++) begin
         step(1, 0, 0, AW'(100 + 2 * i), 2'b11, 2'b11);
         step(1, 0, 1, AW'(101 + 2 * i), 2'b00, 2'b00);
      end
      nops(3);

      // R9: stall with a read in flight, with a write awaiting data, with output valid
      cur_tag = "R9";
      step(1, 0, 1, AW'(20), 2'b11, 2'b11);
      for (int i = 0; i < 3; i++) step(0, 0, 0, AW'(20), 2'b00, 2'b00);
      nops(3);
      step(1, 0, 0, AW'(30), 2'b11, 2'b11);
      for (int i = 0; i < 3; i++) step(0, 0, 1, AW'(31), 2'b00, 2'b00);
      step(1, 1, 0, '0, 2'b10, 2'b00);
      step(1, 0, 1, AW'(30), 2'b11, 2'b11);
      step(1, 1, 0, '0, 2'b11, 2'b11);
      step(1, 1, 0, '0, 2'b11, 2'b11);
      for (int i = 0; i < 3; i++) step(0, 0, 0, AW'(30), 2'b00, 2'b00);
      nops(3);

      // R8: reset between a write command and its data
      cur_tag = "R8";
      step(1, 0, 0, AW'(50), 2'b11, 2'b11);
      do_reset();
      step(1, 1, 0, '0, 2'b00, 2'b00);
      step(1, 0, 1, AW'(50), 2'b11, 2'b11);
      nops(4);

      report();
      $finish;
   end

endmodule